// File: doc/BRIEF.md
# Effective Address Generator

This block resolves the operand address of an instruction for an 8-bit processor with a 16-bit address space. A controller pulses `start_i` and presents the addressing mode, the program counter (pointing at the first operand byte), and the two index registers. The block then fetches the operand bytes, and for the indirect forms the pointer bytes, through a byte-wide read port. It reports the final effective address and the program counter advanced past the operand. The final operand access and any bus-accurate dummy cycles are left to the caller.

Zero-page forms stay inside page zero, and absolute forms carry into the high byte. The indirect jump form takes its pointer high byte from the same page as the low byte. The two zero-page pointer forms fetch the pointer high byte from the full 16-bit successor of the pointer address. The read port issues one registered request per cycle and expects the read data back in that same cycle.

Top module: `addr_resolver`

## Requirements
- R1: While and after reset, with no start, `valid_o` and `mem_rd_o` are 0 and `ea_o` and `pc_next_o` are 0.
- R2: Mode 1 (zero page), mode 2 (zero page + X) and mode 3 (zero page + Y) read one operand byte at PC. The address is {0x00, (operand + index) mod 256}, with index 0 for mode 1. PC advances by 1.
- R3: Mode 0 (immediate) returns the incoming PC as the address and PC+1 as the next PC, and reads nothing.
- R4: Mode 4 (absolute), mode 5 (absolute + X) and mode 6 (absolute + Y) read the low byte at PC and the high byte at PC+1. The index is added modulo 65536, with index 0 for mode 4. PC advances by 2.
- R5: Mode 7 (indirect) reads a 16-bit pointer as in R4. The target low byte comes from the pointer, and the high byte comes from {pointer high, (pointer low + 1) mod 256}. The address is the target. PC advances by 2.
- R6: Mode 8 (pre-indexed indirect) reads the pointer low byte at {0x00, (operand + X) mod 256} and the high byte at that address + 1 in 16 bits, so 0x00FF is followed by 0x0100. The address is that pointer. PC advances by 1.
- R7: Mode 9 (post-indexed indirect) reads the pointer at {0x00, operand} and at its 16-bit successor, then adds Y modulo 65536. PC advances by 1.
- R8: Every PC increment wraps at 16 bits, so an operand at 0xFFFF is followed by one at 0x0000.
- R9: `mem_rd_o` is high only while a resolution is in progress. One byte is read per cycle in which it is high, and `mem_rdata_i` is sampled in that cycle.
- R10: A `start_i` pulse that arrives while a resolution is in progress is ignored.
- R11: `valid_o` is high for exactly one cycle. It rises 1 clock edge after the start edge for modes 0 and 10–15, 2 for modes 1–3, 3 for modes 4–6, 4 for modes 8–9 and 5 for mode 7.
- R12: Mode codes 10 to 15 return the incoming PC as both the address and the next PC, and read nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a resolution; sampled only when idle |
| mode_i | input | 4 | Addressing mode code |
| pc_i | input | 16 | Address of the first operand byte |
| x_i | input | 8 | X index |
| y_i | input | 8 | Y index |
| mem_rdata_i | input | 8 | Read data for the request presented this cycle |
| mem_rd_o | output | 1 | Read request |
| mem_addr_o | output | 16 | Read address |
| ea_o | output | 16 | Effective address |
| pc_next_o | output | 16 | PC after the operand bytes |
| valid_o | output | 1 | One-cycle strobe: `ea_o`/`pc_next_o` are final |

## Verification
The hardest cases to reach sit in memory contents rather than in the port pins: a pointer whose low byte is 0xFF, read once by the indirect form and once by each zero-page pointer form. The bench's memory model lets each scenario plant bytes at chosen addresses over a computed background. It plants different values at 0x3000 and 0x3100, and at 0x0000 and 0x0100, so a wrong high-byte address shows up as a wrong effective address. The dropped-start case is reached by pulsing a second start, with a different mode, one cycle into an absolute fetch.

// File: rtl/addr_res_pkg.sv
package addr_res_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_IMM     = 4'd0,
    AM_ZP      = 4'd1,
    AM_ZPX     = 4'd2,
    AM_ZPY     = 4'd3,
    AM_ABS     = 4'd4,
    AM_ABSX    = 4'd5,
    AM_ABSY    = 4'd6,
    AM_IND     = 4'd7,
    AM_PREIDX  = 4'd8,
    AM_POSTIDX = 4'd9
  } am_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OP0, ST_OP1, ST_PTR0, ST_PTR1
  } seq_st_e;

  function automatic logic is_zp_direct(input logic [MODE_W-1:0] m);
    return (m == AM_ZP) || (m == AM_ZPX) || (m == AM_ZPY);
  endfunction

  function automatic logic is_two_byte(input logic [MODE_W-1:0] m);
    return (m == AM_ABS) || (m == AM_ABSX) || (m == AM_ABSY) || (m == AM_IND);
  endfunction

  function automatic logic is_zp_ptr(input logic [MODE_W-1:0] m);
    return (m == AM_PREIDX) || (m == AM_POSTIDX);
  endfunction

  function automatic logic needs_fetch(input logic [MODE_W-1:0] m);
    return is_zp_direct(m) || is_two_byte(m) || is_zp_ptr(m);
  endfunction

  function automatic logic is_reserved(input logic [MODE_W-1:0] m);
    return m > AM_POSTIDX;
  endfunction
endpackage

// File: rtl/ea_wrap_add.sv
module ea_wrap_add #(
  parameter int DATA_W     = 8,
  parameter bit PAGE_LOCAL = 1'b0,
  localparam int ADDR_W    = 2 * DATA_W
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DATA_W-1:0] inc_i,
  output logic [ADDR_W-1:0] sum_o
);
  generate
    if (PAGE_LOCAL) begin : g_page
      // carry out of the low byte is dropped; page stays put
      assign sum_o = {base_i[ADDR_W-1:DATA_W], base_i[DATA_W-1:0] + inc_i};
    end else begin : g_full
      assign sum_o = base_i + {{DATA_W{1'b0}}, inc_i};
    end
  endgenerate
endmodule

// File: rtl/ea_seq.sv
module ea_seq
  import addr_res_pkg::*;
#(
  parameter int DATA_W  = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [ADDR_W-1:0] pc_inc1_i,
  input  logic [ADDR_W-1:0] zp_ptr_lo_i,
  input  logic [ADDR_W-1:0] zp_ptr_hi_i,
  input  logic [ADDR_W-1:0] ind_hi_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [MODE_W-1:0] ctx_mode_o,
  output logic [ADDR_W-1:0] ctx_pc_o,
  output logic [DATA_W-1:0] ctx_x_o,
  output logic [DATA_W-1:0] ctx_y_o,
  output logic [DATA_W-1:0] op0_o,
  output logic [DATA_W-1:0] op1_o,
  output logic [DATA_W-1:0] p0_o,
  output logic [DATA_W-1:0] p1_o,
  output logic              done_o
);
  seq_st_e           st_q;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [MODE_W-1:0] mode_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] x_q, y_q;
  logic [DATA_W-1:0] op0_q, op1_q, p0_q, p1_q;

  assign mem_rd_o   = rd_q;
  assign mem_addr_o = addr_q;

  // context: live inputs while idle, latched copy once busy
  always_comb begin
    ctx_mode_o = (st_q == ST_IDLE) ? mode_i : mode_q;
    ctx_pc_o   = (st_q == ST_IDLE) ? pc_i   : pc_q;
    ctx_x_o    = (st_q == ST_IDLE) ? x_i    : x_q;
    ctx_y_o    = (st_q == ST_IDLE) ? y_i    : y_q;
    op0_o      = (st_q == ST_OP0)  ? mem_rdata_i : op0_q;
    op1_o      = (st_q == ST_OP1)  ? mem_rdata_i : op1_q;
    p0_o       = (st_q == ST_PTR0) ? mem_rdata_i : p0_q;
    p1_o       = (st_q == ST_PTR1) ? mem_rdata_i : p1_q;
  end

  always_comb begin
    done_o = 1'b0;
    case (st_q)
      ST_IDLE: done_o = start_i && !needs_fetch(mode_i);
      ST_OP0:  done_o = is_zp_direct(mode_q);
      ST_OP1:  done_o = (mode_q != AM_IND);
      ST_PTR1: done_o = 1'b1;
      default: done_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      rd_q   <= 1'b0;
      addr_q <= '0;
      mode_q <= '0;
      pc_q   <= '0;
      x_q    <= '0;
      y_q    <= '0;
      op0_q  <= '0;
      op1_q  <= '0;
      p0_q   <= '0;
      p1_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            mode_q <= mode_i;
            pc_q   <= pc_i;
            x_q    <= x_i;
            y_q    <= y_i;
            if (needs_fetch(mode_i)) begin
              rd_q   <= 1'b1;
              addr_q <= pc_i;
              st_q   <= ST_OP0;
            end
          end
        end
        ST_OP0: begin
          op0_q <= mem_rdata_i;
          if (is_two_byte(mode_q)) begin
            addr_q <= pc_inc1_i;
            st_q   <= ST_OP1;
          end else if (is_zp_ptr(mode_q)) begin
            addr_q <= zp_ptr_lo_i;
            st_q   <= ST_PTR0;
          end else begin
            rd_q <= 1'b0;
            st_q <= ST_IDLE;
          end
        end
        ST_OP1: begin
          op1_q <= mem_rdata_i;
          if (mode_q == AM_IND) begin
            addr_q <= {mem_rdata_i, op0_q};
            st_q   <= ST_PTR0;
          end else begin
            rd_q <= 1'b0;
            st_q <= ST_IDLE;
          end
        end
        ST_PTR0: begin
          p0_q   <= mem_rdata_i;
          addr_q <= (mode_q == AM_IND) ? ind_hi_i : zp_ptr_hi_i;
          st_q   <= ST_PTR1;
        end
        ST_PTR1: begin
          p1_q <= mem_rdata_i;
          rd_q <= 1'b0;
          st_q <= ST_IDLE;
        end
        default: begin
          rd_q <= 1'b0;
          st_q <= ST_IDLE;
        end
      endcase
    end
  end

  // R9: reads only happen while a resolution is under way
  assert_rd_only_busy_R9: assert property (@(posedge clk) disable iff (rst)
    mem_rd_o |-> (st_q != ST_IDLE));

  // R4: the first fetch of every operand is at the latched PC
  assert_first_fetch_pc_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_OP0) |-> (mem_addr_o == pc_q));

  // R5: indirect high-byte fetch stays on the pointer's page
  assert_ind_hi_same_page_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PTR1 && mode_q == AM_IND) |->
      (mem_addr_o[ADDR_W-1:DATA_W] == $past(mem_addr_o[ADDR_W-1:DATA_W])));

  // R6: zero-page pointer low byte is fetched from page zero
  assert_zp_ptr_page0_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PTR0 && is_zp_ptr(mode_q)) |-> (mem_addr_o[ADDR_W-1:DATA_W] == '0));

  // R10: latched PC is frozen while busy
  assert_busy_holds_ctx_R10: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE) |=> $stable(pc_q));
endmodule

// File: rtl/ea_out.sv
module ea_out
  import addr_res_pkg::*;
#(
  parameter int DATA_W  = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] zp_idx_i,
  input  logic [ADDR_W-1:0] abs_idx_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [ADDR_W-1:0] post_i,
  input  logic [ADDR_W-1:0] pc_p1_i,
  input  logic [ADDR_W-1:0] pc_p2_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              valid_o
);
  logic [ADDR_W-1:0] ea_d, pc_d;
  logic [MODE_W-1:0] mode_r;

  always_comb begin
    ea_d = pc_i;
    pc_d = pc_i;
    case (mode_i)
      AM_IMM:                  begin ea_d = pc_i;      pc_d = pc_p1_i; end
      AM_ZP, AM_ZPX, AM_ZPY:   begin ea_d = zp_idx_i;  pc_d = pc_p1_i; end
      AM_ABS, AM_ABSX, AM_ABSY: begin ea_d = abs_idx_i; pc_d = pc_p2_i; end
      AM_IND:                  begin ea_d = ptr_i;     pc_d = pc_p2_i; end
      AM_PREIDX:               begin ea_d = ptr_i;     pc_d = pc_p1_i; end
      AM_POSTIDX:              begin ea_d = post_i;    pc_d = pc_p1_i; end
      default:                 begin ea_d = pc_i;      pc_d = pc_i;    end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_o    <= '0;
      pc_o    <= '0;
      valid_o <= 1'b0;
      mode_r  <= '0;
    end else begin
      valid_o <= done_i;
      if (done_i) begin
        ea_o   <= ea_d;
        pc_o   <= pc_d;
        mode_r <= mode_i;
      end
    end
  end

  // R2: zero-page results never leave page zero
  assert_zp_page0_R2: assert property (@(posedge clk) disable iff (rst)
    (valid_o && is_zp_direct(mode_r)) |-> (ea_o[ADDR_W-1:DATA_W] == '0));

  // R12: reserved codes leave PC where it was and point at it
  assert_reserved_pc_R12: assert property (@(posedge clk) disable iff (rst)
    (valid_o && is_reserved(mode_r)) |-> (ea_o == pc_o));
endmodule

// File: rtl/addr_resolver.sv
module addr_resolver
  import addr_res_pkg::*;
#(
  parameter int DATA_W  = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W-1:0] ea_o,
  output logic [ADDR_W-1:0] pc_next_o,
  output logic              valid_o
);
  logic [MODE_W-1:0] ctx_mode;
  logic [ADDR_W-1:0] ctx_pc;
  logic [DATA_W-1:0] ctx_x, ctx_y;
  logic [DATA_W-1:0] op0, op1, p0, p1;
  logic              done;
  logic [DATA_W-1:0] zp_inc, abs_inc;
  logic [ADDR_W-1:0] zp_idx, zp_ptr_hi, ind_hi, abs_idx, post_idx, pc_p1, pc_p2;

  always_comb begin
    case (ctx_mode)
      AM_ZPX, AM_PREIDX: zp_inc = ctx_x;
      AM_ZPY:            zp_inc = ctx_y;
      default:           zp_inc = '0;
    endcase
    case (ctx_mode)
      AM_ABSX: abs_inc = ctx_x;
      AM_ABSY: abs_inc = ctx_y;
      default: abs_inc = '0;
    endcase
  end

  ea_wrap_add #(.DATA_W(DATA_W), .PAGE_LOCAL(1'b1)) u_zp_idx (
    .base_i({{DATA_W{1'b0}}, op0}), .inc_i(zp_inc), .sum_o(zp_idx));
  ea_wrap_add #(.DATA_W(DATA_W), .PAGE_LOCAL(1'b0)) u_zp_ptr_hi (
    .base_i(zp_idx), .inc_i(DATA_W'(1)), .sum_o(zp_ptr_hi));
  ea_wrap_add #(.DATA_W(DATA_W), .PAGE_LOCAL(1'b1)) u_ind_hi (
    .base_i({op1, op0}), .inc_i(DATA_W'(1)), .sum_o(ind_hi));
  ea_wrap_add #(.DATA_W(DATA_W), .PAGE_LOCAL(1'b0)) u_abs_idx (
    .base_i({op1, op0}), .inc_i(abs_inc), .sum_o(abs_idx));
  ea_wrap_add #(.DATA_W(DATA_W), .PAGE_LOCAL(1'b0)) u_post (
    .base_i({p1, p0}), .inc_i(ctx_y), .sum_o(post_idx));
  ea_wrap_add #(.DATA_W(DATA_W), .PAGE_LOCAL(1'b0)) u_pc1 (
    .base_i(ctx_pc), .inc_i(DATA_W'(1)), .sum_o(pc_p1));
  ea_wrap_add #(.DATA_W(DATA_W), .PAGE_LOCAL(1'b0)) u_pc2 (
    .base_i(ctx_pc), .inc_i(DATA_W'(2)), .sum_o(pc_p2));

  ea_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .pc_i(pc_i), .x_i(x_i), .y_i(y_i), .mem_rdata_i(mem_rdata_i),
    .pc_inc1_i(pc_p1), .zp_ptr_lo_i(zp_idx), .zp_ptr_hi_i(zp_ptr_hi),
    .ind_hi_i(ind_hi), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .ctx_mode_o(ctx_mode), .ctx_pc_o(ctx_pc), .ctx_x_o(ctx_x), .ctx_y_o(ctx_y),
    .op0_o(op0), .op1_o(op1), .p0_o(p0), .p1_o(p1), .done_o(done));

  ea_out #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .done_i(done), .mode_i(ctx_mode), .pc_i(ctx_pc),
    .zp_idx_i(zp_idx), .abs_idx_i(abs_idx), .ptr_i({p1, p0}),
    .post_i(post_idx), .pc_p1_i(pc_p1), .pc_p2_i(pc_p2),
    .ea_o(ea_o), .pc_o(pc_next_o), .valid_o(valid_o));
endmodule

// File: tb/addr_resolver_tb_top.sv
module addr_resolver_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] pc = '0;
  logic [7:0]  x = '0, y = '0;
  logic [7:0]  mem_rdata;
  logic        mem_rd, valid;
  logic [15:0] mem_addr, ea, pc_next;

  int n_checks = 0, n_fail = 0, cyc = 0;

  logic [15:0] ov_a [8];
  logic [7:0]  ov_d [8];
  int ov_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  addr_resolver dut_i (
    .clk(clk), .rst(rst), .start_i(start), .mode_i(mode), .pc_i(pc),
    .x_i(x), .y_i(y), .mem_rdata_i(mem_rdata), .mem_rd_o(mem_rd),
    .mem_addr_o(mem_addr), .ea_o(ea), .pc_next_o(pc_next), .valid_o(valid));

  function automatic logic [7:0] bg(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  always_comb begin
    mem_rdata = bg(mem_addr);
    for (int i = 0; i < 8; i++)
      if (i < ov_n && ov_a[i] == mem_addr) mem_rdata = ov_d[i];
  end

  task automatic poke(input logic [15:0] a, input logic [7:0] d);
    ov_a[ov_n] = a; ov_d[ov_n] = d; ov_n++;
  endtask

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run_case(input string tag, input logic [3:0] m, input logic [15:0] p,
                          input logic [7:0] xi, input logic [7:0] yi,
                          input logic [15:0] exp_ea, input logic [15:0] exp_pc,
                          input int exp_lat);
    int lat = 1;
    int reads = 0;
    @(negedge clk);
    start = 1'b1; mode = m; pc = p; x = xi; y = yi;
    @(negedge clk);
    start = 1'b0;
    while (!valid && lat < 12) begin
      if (mem_rd) reads++;
      @(negedge clk);
      lat++;
    end
    if (mem_rd) reads++;
    check(valid, tag, "valid seen", 32'(valid), 1);
    check(ea == exp_ea, tag, "address", 32'(ea), 32'(exp_ea));
    check(pc_next == exp_pc, tag, "next pc", 32'(pc_next), 32'(exp_pc));
    check(lat == exp_lat, "R11", "latency", 32'(lat), 32'(exp_lat));
    check(reads == exp_lat - 1, "R9", "read count", 32'(reads), 32'(exp_lat - 1));
    @(negedge clk);
    check(!valid, "R11", "valid one cycle", 32'(valid), 0);
    ov_n = 0;
  endtask

  task automatic t_reset;
    check(!valid && !mem_rd, "R1", "strobes in reset", {30'b0, valid, mem_rd}, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(!valid && !mem_rd, "R1", "strobes after reset", {30'b0, valid, mem_rd}, 0);
    check(ea == 16'h0 && pc_next == 16'h0, "R1", "outputs after reset", {ea, pc_next}, 0);
  endtask

  task automatic t_immediate;
    run_case("R3", 4'd0, 16'h1234, 8'h11, 8'h22, 16'h1234, 16'h1235, 1);
  endtask

  task automatic t_zero_page;
    poke(16'h0200, 8'h47);
    run_case("R2", 4'd1, 16'h0200, 8'h33, 8'h44, 16'h0047, 16'h0201, 2);
    poke(16'h0300, 8'hF0);
    run_case("R2", 4'd2, 16'h0300, 8'h20, 8'h00, 16'h0010, 16'h0301, 2);
    poke(16'h0310, 8'h80);
    run_case("R2", 4'd3, 16'h0310, 8'h77, 8'h05, 16'h0085, 16'h0311, 2);
  endtask

  task automatic t_absolute;
    poke(16'h0400, 8'h34); poke(16'h0401, 8'h12);
    run_case("R4", 4'd4, 16'h0400, 8'h55, 8'h66, 16'h1234, 16'h0402, 3);
    poke(16'h0410, 8'hF0); poke(16'h0411, 8'h12);
    run_case("R4", 4'd5, 16'h0410, 8'h20, 8'h00, 16'h1310, 16'h0412, 3);
    poke(16'h0420, 8'hFF); poke(16'h0421, 8'hFF);
    run_case("R4", 4'd6, 16'h0420, 8'h00, 8'h02, 16'h0001, 16'h0422, 3);
  endtask

  task automatic t_indirect;
    poke(16'h0500, 8'h10); poke(16'h0501, 8'h30);
    poke(16'h3010, 8'hCD); poke(16'h3011, 8'hAB);
    run_case("R5", 4'd7, 16'h0500, 8'h00, 8'h00, 16'hABCD, 16'h0502, 5);
    // pointer at page end: high byte from start of the same page
    poke(16'h0510, 8'hFF); poke(16'h0511, 8'h30);
    poke(16'h30FF, 8'h78); poke(16'h3000, 8'h56); poke(16'h3100, 8'h99);
    run_case("R5", 4'd7, 16'h0510, 8'h00, 8'h00, 16'h5678, 16'h0512, 5);
  endtask

  task automatic t_pre_indexed;
    poke(16'h0600, 8'h40); poke(16'h0045, 8'h00); poke(16'h0046, 8'h90);
    run_case("R6", 4'd8, 16'h0600, 8'h05, 8'h00, 16'h9000, 16'h0601, 4);
    poke(16'h0620, 8'hF0); poke(16'h0010, 8'hAA); poke(16'h0011, 8'hBB);
    poke(16'h0110, 8'h01);
    run_case("R6", 4'd8, 16'h0620, 8'h20, 8'h00, 16'hBBAA, 16'h0621, 4);
    // pointer at 0x00FF: high byte from 0x0100
    poke(16'h0610, 8'hFE); poke(16'h00FF, 8'h22); poke(16'h0100, 8'h11);
    poke(16'h0000, 8'hEE);
    run_case("R6", 4'd8, 16'h0610, 8'h01, 8'h00, 16'h1122, 16'h0611, 4);
  endtask

  task automatic t_post_indexed;
    poke(16'h0700, 8'h80); poke(16'h0080, 8'h00); poke(16'h0081, 8'h20);
    run_case("R7", 4'd9, 16'h0700, 8'h99, 8'h10, 16'h2010, 16'h0701, 4);
    poke(16'h0710, 8'hFF); poke(16'h00FF, 8'hF0); poke(16'h0100, 8'hFF);
    poke(16'h0000, 8'h33);
    run_case("R7", 4'd9, 16'h0710, 8'h00, 8'h20, 16'h0010, 16'h0711, 4);
  endtask

  task automatic t_pc_wrap;
    poke(16'hFFFF, 8'hCD); poke(16'h0000, 8'hAB);
    run_case("R8", 4'd4, 16'hFFFF, 8'h00, 8'h00, 16'hABCD, 16'h0001, 3);
    run_case("R8", 4'd0, 16'hFFFF, 8'h00, 8'h00, 16'hFFFF, 16'h0000, 1);
  endtask

  task automatic t_reserved;
    run_case("R12", 4'd12, 16'h4321, 8'h01, 8'h02, 16'h4321, 16'h4321, 1);
    run_case("R12", 4'd15, 16'h0042, 8'h01, 8'h02, 16'h0042, 16'h0042, 1);
  endtask

  task automatic t_busy_start;
    int seen = 0;
    logic [15:0] got_ea = '0, got_pc = '0;
    poke(16'h0400, 8'h34); poke(16'h0401, 8'h12);
    @(negedge clk);
    start = 1'b1; mode = 4'd4; pc = 16'h0400;
    @(negedge clk);
    mode = 4'd0; pc = 16'hBEEF;   // second pulse while busy
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (valid) begin seen++; got_ea = ea; got_pc = pc_next; end
      @(negedge clk);
    end
    check(seen == 1, "R10", "valid count", 32'(seen), 1);
    check(got_ea == 16'h1234, "R10", "address", 32'(got_ea), 32'h1234);
    check(got_pc == 16'h0402, "R10", "next pc", 32'(got_pc), 32'h0402);
    ov_n = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_immediate();
    t_zero_page();
    t_absolute();
    t_indirect();
    t_pre_indexed();
    t_post_indexed();
    t_pc_wrap();
    t_reserved();
    t_busy_start();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait (cyc >= WATCHDOG);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule